// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the sixteen-times oversampling strobe of an asynchronous serial port from the peripheral clock. Software programs a divider word whose upper field holds a whole divisor together with two fractional bits, so the divisor is resolved to a quarter of a clock. The generator turns that word into a one-cycle enable, `tick_o`, whose average rate is the clock rate divided by (4 + N)/4, where N is the divider word shifted right by the number of ignored low bits. The receiver and transmitter frame logic downstream use each tick as one sixteenth of a bit.

The fraction is produced by a phase accumulator. Each clock it advances by four. When the running sum reaches 4 + N, it emits a tick and takes 4 + N off the sum. Individual tick spacings therefore differ by at most one clock, and over any long window the spacing averages exactly (4 + N)/4 clocks. The serial bit rate is then 4·fclk / (16·(4 + N)). With the default 15-bit divisor field, this spans from about fclk/(16·8192) up to fclk/16.

Top module: `baudfrac_tick`

## Requirements
- R1: While `rst_n` is low, `tick_o` is 0. The accumulator starts from zero and the stored divisor field is 0.
- R2: Bits 5:0 of `div_reg` have no effect. Changing only those bits neither restarts the accumulator nor alters the tick pattern.
- R3: N is `div_reg[20:6]`. After a restart, the tick for clock m (m = 1, 2, ...) is 1 exactly when floor(4m/(4+N)) > floor(4(m-1)/(4+N)). Over M clocks, this gives floor(4M/(4+N)) ticks.
- R4: When N = 0, `tick_o` is 1 on every clock.
- R5: When N differs from the value seen at the previous clock edge, that edge clears the accumulator and drives `tick_o` to 0. Counting of m for R3 then begins at the following edge.
- R6: The largest divisor field, N = 32767, gives tick spacings of 8192 or 8193 clocks with no overflow of the accumulator.
- R7: For N ≥ 4 with the divisor held, `tick_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_reg | input | 21 | Divider word: bits 20:6 are N (two fractional bits at 7:6), bits 5:0 ignored |
| tick_o | output | 1 | One-cycle oversampling enable |

## Verification
The tick stream is compared on every clock against the floor-based formula of R3, first with N = 0 and then with a run of random divisors. Among the random runs, divisors that are multiples of four separate the integer path from divisors whose fractional bits alternate spacings. The largest divisor field exposes any accumulator width or wrap fault over a window of four ticks. A run that scrambles only the six low bits must leave the stream identical to an undisturbed run, which tells apart a correct field select from a restart triggered by those bits. Each divisor change is also checked for the forced idle clock and the clean restart.

// File: rtl/baudfrac_pkg.sv
package baudfrac_pkg;
  // Phase advance per clock: four quarter-steps make one whole clock.
  localparam int unsigned PHASE_STEP = 4;
endpackage

// File: rtl/baudfrac_divcap.sv
module baudfrac_divcap #(
  parameter int unsigned N_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N_W-1:0] field_i,
  output logic [N_W-1:0] field_q,
  output logic           restart_o
);
  logic [N_W-1:0] field_d;

  always_comb begin
    restart_o = (field_i != field_q);
    field_d   = restart_o ? field_i : field_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= '0;
    end else begin
      field_q <= field_d;
    end
  end
endmodule

// File: rtl/baudfrac_phase.sv
module baudfrac_phase
  import baudfrac_pkg::*;
#(
  parameter int unsigned N_W = 15
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           restart_i,
  input  logic [N_W-1:0] div_i,
  output logic           tick_o
);
  localparam int unsigned ACC_W = N_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] thresh;
  logic             tick_d;
  logic             tick_q;

  always_comb begin
    sum    = acc_q + ACC_W'(PHASE_STEP);
    thresh = {1'b0, div_i} + ACC_W'(PHASE_STEP);
    if (restart_i) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else if (sum >= thresh) begin
      acc_d  = sum - thresh;
      tick_d = 1'b1;
    end else begin
      acc_d  = sum;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/baudfrac_tick.sv
module baudfrac_tick #(
  parameter int unsigned DIV_W    = 21,
  parameter int unsigned FRAC_LSB = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_reg,
  output logic             tick_o
);
  localparam int unsigned N_W = DIV_W - FRAC_LSB;

  logic [N_W-1:0] field_in;
  logic [N_W-1:0] field_q;
  logic           restart;

  // The low FRAC_LSB bits carry no weight and are dropped here (R2).
  assign field_in = div_reg[DIV_W-1:FRAC_LSB];

  baudfrac_divcap #(.N_W(N_W)) u_divcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .field_i   (field_in),
    .field_q   (field_q),
    .restart_o (restart)
  );

  baudfrac_phase #(.N_W(N_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .div_i     (field_q),
    .tick_o    (tick_o)
  );
endmodule

// File: rtl/baudfrac_tick_chk.sv
module baudfrac_tick_chk #(
  parameter int unsigned DIV_W    = 21,
  parameter int unsigned FRAC_LSB = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_reg,
  input logic             tick_o
);
  localparam int unsigned N_W = DIV_W - FRAC_LSB;

  logic [N_W-1:0] fld;
  assign fld = div_reg[DIV_W-1:FRAC_LSB];

  // R1: reset holds the strobe low
  always_comb begin
    if (!rst_n) begin
      p_low_in_reset_r1: assert (tick_o == 1'b0);
    end
  end

  // R5: a divisor change forces one idle clock
  p_idle_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fld != $past(fld)) |=> !tick_o);

  // R4: zero divisor ticks every clock
  p_every_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fld == '0 && $past(fld) == '0) |=> tick_o);

  // R7: with N >= 4 ticks never come back to back
  p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && fld >= N_W'(4) && $stable(fld)) |=> !tick_o);

  p_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(tick_o));
endmodule

bind baudfrac_tick baudfrac_tick_chk #(.DIV_W(DIV_W), .FRAC_LSB(FRAC_LSB)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .div_reg (div_reg),
  .tick_o  (tick_o)
);

// File: tb/baudfrac_tick_test.sv
module baudfrac_tick_test;
  logic        clk;
  logic        rst_n;
  logic [20:0] div_reg;
  logic        tick_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  baudfrac_tick uut (.clk(clk), .rst_n(rst_n), .div_reg(div_reg), .tick_o(tick_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_tick(int n, int m);
    int d = 4 + n;
    return ((4 * m) / d) > ((4 * (m - 1)) / d);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive new field at a negedge, then check idle clock and M clocks of pattern.
  task automatic run(string req, int n, int cyc, bit scramble);
    int cnt = 0;
    div_reg = {n[14:0], 6'(($urandom))};
    @(posedge clk); @(negedge clk);
    check("R5", int'(tick_o), 0);
    for (int m = 1; m <= cyc; m++) begin
      @(posedge clk); @(negedge clk);
      check(req, int'(tick_o), int'(exp_tick(n, m)));
      if (tick_o) cnt++;
      if (scramble) div_reg[5:0] = 6'($urandom);
    end
    check({req, " total"}, cnt, (4 * cyc) / (4 + n));
  endtask

  initial begin
    int prev;
    int n;
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    div_reg = {15'd3, 6'h2a};
    #20;
    @(negedge clk);
    check("R1", int'(tick_o), 0);
    @(negedge clk);
    check("R1", int'(tick_o), 0);
    rst_n = 1'b1;
    // first edge sees 3 vs reset value 0: restart (R5), then pattern (R3)
    @(posedge clk); @(negedge clk);
    check("R5", int'(tick_o), 0);
    for (int m = 1; m <= 30; m++) begin
      @(posedge clk); @(negedge clk);
      check("R3", int'(tick_o), int'(exp_tick(3, m)));
    end
    run("R4", 0, 20, 1'b0);
    run("R2", 5, 60, 1'b1);
    run("R7", 4, 40, 1'b0);
    run("R3", 1, 40, 1'b0);
    prev = 1;
    for (int i = 0; i < 12; i++) begin
      n = $urandom_range(2, 300);
      if (n == prev) n = n + 1;
      run("R3", n, 4 * (4 + n) + 5, 1'b0);
      prev = n;
    end
    run("R6", 32767, 33000, 1'b0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule